// File: doc/BRIEF.md
# Display Enable Clock-Domain Handshake

This block carries a single software enable bit from the bus clock domain into a slow display clock domain. It reports back to software when the display engine has actually switched on or off. Software writes the enable bit through a one-cycle write strobe. It reads a control word whose bit 0 shows the enable state that has taken effect in the display domain, and whose bit 31 shows that a change is still in flight. The display timing logic supplies a frame-end pulse in the display domain and receives the enable level it should run with.

Turning the display on takes effect shortly after the request crosses into the display domain. Turning it off is held back until the current frame ends, so that a frame is never cut short. The two domains exchange a level-based four-phase handshake. The bus side forwards a new request only after the display side has acknowledged the previous one. If software changes its mind while a change is pending, the block therefore works through the pending change and then settles on the most recent written value. The display-domain enable is never chopped into a short pulse.

The bus side runs a four-state machine. Its states are BUS_OFF, BUS_RISING, BUS_ON and BUS_FALLING, and it has these transitions:
- launch-on: BUS_OFF to BUS_RISING, when the written value is 1.
- ack-on: BUS_RISING to BUS_ON, when the synchronised acknowledge is 1.
- launch-off: BUS_ON to BUS_FALLING, when the written value is 0.
- ack-off: BUS_FALLING to BUS_OFF, when the synchronised acknowledge is 0.

The display side runs a three-state machine. Its states are DSP_OFF, DSP_ON and DSP_DRAIN, and it has these transitions:
- start: DSP_OFF to DSP_ON, when the synchronised request is 1.
- stop-now: DSP_ON to DSP_OFF, when the request is 0 and a frame ends in the same cycle.
- hold: DSP_ON to DSP_DRAIN, when the request is 0 and no frame ends.
- frame-done: DSP_DRAIN to DSP_OFF, when a frame ends.
- resume: DSP_DRAIN to DSP_ON, when the request returns.

Top module: `disp_enable_cdc`

## Requirements
- R1: While reset is asserted and right after it, the control word reads 0 and the display enable is 0.
- R2: After a write of 1, bit 0 of the control word keeps reading 0 until the display enable is already 1. After a write of 0, bit 0 keeps reading 1 until the display enable is already 0. Bit 0 changes only in a cycle that directly follows a cycle with bit 31 set.
- R3: Once a request to enable is accepted, the display enable rises at the second display clock rising edge after the request is forwarded. The delay from the write edge is more than one and at most two display periods plus one bus period. While the synchronised request is 1, the display enable is 1.
- R4: A write whose value differs from the settled bit 0 sets bit 31 in the next bus cycle. Bit 31 stays 1 until bit 0 equals the latest written value and the handshake is idle, and then it returns to 0.
- R5: The display enable falls only at a display clock edge where the frame-end input is 1. A disable request therefore keeps the display on, and bit 31 set, for as long as no frame ends.
- R6: Writing the value that bit 0 already shows, with nothing pending, leaves bit 31 at 0 and the control word unchanged.
- R7: If the written value is toggled back while a change is pending, the pending change completes first. The block then settles on the latest written value, with bit 0, bit 31 and the display enable consistent with it. A new request is forwarded only when the previous one has been acknowledged.
- R8: A frame-end pulse has no effect on the display enable while the display is off with no request, or while it is on with the enable requested.
- R9: Bits 30 down to 1 of the control word always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus-side clock |
| clk_disp | input | 1 | Slow display clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ctl_wr_i | input | 1 | One-cycle write strobe for the enable bit (bus domain) |
| ctl_wdata_i | input | 1 | Enable value being written |
| frame_end_i | input | 1 | End-of-frame pulse (display domain) |
| ctl_rdata_o | output | CTRL_W | Control word: bit 0 effective enable, bit CTRL_W-1 busy |
| disp_en_o | output | 1 | Enable level used by the display domain |

## Verification
The assertions check four rules on every cycle. The readback bit moves only right after a busy cycle. A forwarded request changes only once the previous one is acknowledged. The display enable drops only after a frame-end pulse and is always high while the synchronised request is high. The acknowledge rises only once the enable is already on. The bench scenarios show the effects that span both clocks. These are the enable latency measured in time from the write, a disable held off across many display cycles until a frame ends, and a request reversed during a pending disable that still settles on the newest value. They also include a back-to-back on/off write, and random write sequences against free-running frame pulses that must always come to rest on the last written value.

// File: rtl/disp_enable_cdc_pkg.sv
package disp_enable_cdc_pkg;

    // Bus side: bit 1 is the forwarded request, bit 0 the synchronised acknowledge.
    typedef enum logic [1:0] {
        BUS_OFF     = 2'b00,
        BUS_RISING  = 2'b10,
        BUS_ON      = 2'b11,
        BUS_FALLING = 2'b01
    } bus_state_e;

    typedef enum logic [1:0] {
        DSP_OFF   = 2'b00,
        DSP_ON    = 2'b01,
        DSP_DRAIN = 2'b10
    } disp_state_e;

endpackage

// File: rtl/dec_sync.sv
module dec_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES < 2) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dec_bus_ctrl.sv
module dec_bus_ctrl
    import disp_enable_cdc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wdata_i,
    input  logic ack_async_i,
    output logic fwd_o,
    output logic rdbk_o,
    output logic busy_o
);

    logic       req_q;
    logic       ack_s;
    logic       fwd_q;
    logic       pending;
    bus_state_e st_q;
    bus_state_e st_d;

    dec_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ack_async_i),
        .q_o   (ack_s)
    );

    // Latest value written by software.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    req_q <= 1'b0;
        else if (wr_i) req_q <= wdata_i;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BUS_OFF;
        else        st_q <= st_d;
    end

    // Next state: launch only when the previous request has been acknowledged.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_OFF:     if (req_q)  st_d = BUS_RISING;   // launch-on
            BUS_RISING:  if (ack_s)  st_d = BUS_ON;       // ack-on
            BUS_ON:      if (!req_q) st_d = BUS_FALLING;  // launch-off
            BUS_FALLING: if (!ack_s) st_d = BUS_OFF;      // ack-off
            default:                 st_d = BUS_OFF;
        endcase
    end

    // Forwarded request leaves this domain from a dedicated flop.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fwd_q <= 1'b0;
        else        fwd_q <= (st_d == BUS_RISING) || (st_d == BUS_ON);
    end

    // Outputs decoded from the state.
    always_comb begin
        rdbk_o  = 1'b0;
        pending = 1'b0;
        unique case (st_q)
            BUS_OFF:     begin rdbk_o = 1'b0; pending = 1'b0; end
            BUS_RISING:  begin rdbk_o = 1'b0; pending = 1'b1; end
            BUS_ON:      begin rdbk_o = 1'b1; pending = 1'b0; end
            BUS_FALLING: begin rdbk_o = 1'b1; pending = 1'b1; end
            default:     begin rdbk_o = 1'b0; pending = 1'b0; end
        endcase
    end

    assign fwd_o  = fwd_q;
    assign busy_o = pending || (req_q != rdbk_o);

    AST_RDBK_MOVES_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rdbk_o != $past(rdbk_o)) |-> $past(busy_o)); // R2

    AST_CHANGE_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (wdata_i != rdbk_o) && !busy_o) |=> busy_o); // R4

    AST_FWD_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_o != $past(fwd_o)) |-> ($past(ack_s) == $past(fwd_o))); // R7

endmodule

// File: rtl/dec_disp_ctrl.sv
module dec_disp_ctrl
    import disp_enable_cdc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async_i,
    input  logic frame_end_i,
    output logic disp_en_o,
    output logic ack_o
);

    logic        req_s;
    logic        ack_q;
    disp_state_e st_q;
    disp_state_e st_d;

    dec_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (req_async_i),
        .q_o   (req_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DSP_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DSP_OFF: if (req_s) st_d = DSP_ON;                         // start
            DSP_ON: begin
                if (!req_s) st_d = frame_end_i ? DSP_OFF : DSP_DRAIN;  // stop-now / hold
            end
            DSP_DRAIN: begin
                if (req_s)            st_d = DSP_ON;                   // resume
                else if (frame_end_i) st_d = DSP_OFF;                  // frame-done
            end
            default: st_d = DSP_OFF;
        endcase
    end

    // Acknowledge leaves this domain from a dedicated flop.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= (st_d != DSP_OFF);
    end

    // Enable follows the synchronised request at once when starting.
    always_comb begin
        disp_en_o = 1'b0;
        unique case (st_q)
            DSP_OFF:   disp_en_o = req_s;
            DSP_ON:    disp_en_o = 1'b1;
            DSP_DRAIN: disp_en_o = 1'b1;
            default:   disp_en_o = 1'b0;
        endcase
    end

    assign ack_o = ack_q;

    AST_DROP_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disp_en_o) |-> $past(frame_end_i)); // R5

    AST_ON_WHEN_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_s |-> disp_en_o); // R3

    AST_ACK_AFTER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(disp_en_o)); // R2

endmodule

// File: rtl/disp_enable_cdc.sv
module disp_enable_cdc #(
    parameter int CTRL_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_bus,
    input  logic              clk_disp,
    input  logic              rst_n,
    input  logic              ctl_wr_i,
    input  logic              ctl_wdata_i,
    input  logic              frame_end_i,
    output logic [CTRL_W-1:0] ctl_rdata_o,
    output logic              disp_en_o
);

    localparam int EN_POS   = 0;
    localparam int BUSY_POS = CTRL_W - 1;

    logic fwd;
    logic ack;
    logic rdbk;
    logic busy;

    dec_bus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
        .clk         (clk_bus),
        .rst_n       (rst_n),
        .wr_i        (ctl_wr_i),
        .wdata_i     (ctl_wdata_i),
        .ack_async_i (ack),
        .fwd_o       (fwd),
        .rdbk_o      (rdbk),
        .busy_o      (busy)
    );

    dec_disp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_disp (
        .clk         (clk_disp),
        .rst_n       (rst_n),
        .req_async_i (fwd),
        .frame_end_i (frame_end_i),
        .disp_en_o   (disp_en_o),
        .ack_o       (ack)
    );

    always_comb begin
        ctl_rdata_o           = '0;
        ctl_rdata_o[EN_POS]   = rdbk;
        ctl_rdata_o[BUSY_POS] = busy;
    end

    AST_IDLE_MATCHES_REQUEST: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (!busy && !ctl_wr_i) |=> !busy); // R6

endmodule

// File: tb/test_disp_enable_cdc.sv
`timescale 1ns/1ps
module test_disp_enable_cdc;

    localparam int  W         = 32;
    localparam real TB        = 8.0;
    localparam real TD        = 52.0;
    localparam int  FRAME_LEN = 9;

    logic         clk_bus = 1'b0;
    logic         clk_disp = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr = 1'b0;
    logic         wdata = 1'b0;
    logic         frame_end = 1'b0;
    logic [W-1:0] rdata;
    logic         disp_en;

    int n_chk = 0;
    int n_err = 0;
    int n_fall = 0;
    bit fe_auto = 0;
    bit fe_one = 0;
    bit done = 0;

    disp_enable_cdc #(.CTRL_W(W), .SYNC_STAGES(2)) i_disp_enable_cdc (
        .clk_bus     (clk_bus),
        .clk_disp    (clk_disp),
        .rst_n       (rst_n),
        .ctl_wr_i    (wr),
        .ctl_wdata_i (wdata),
        .frame_end_i (frame_end),
        .ctl_rdata_o (rdata),
        .disp_en_o   (disp_en)
    );

    always #(TB/2) clk_bus = ~clk_bus;
    always #(TD/2) clk_disp = ~clk_disp;

    function automatic logic [W-1:0] exp_word(input bit en, input bit busy);
        logic [W-1:0] v;
        v = '0;
        v[0] = en;
        v[W-1] = busy;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    // Frame-end driver, changes just after the display falling edge.
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk_disp);
            #1;
            if (fe_auto) begin
                cnt = (cnt == FRAME_LEN - 1) ? 0 : cnt + 1;
                frame_end = (cnt == 0);
            end else if (fe_one) begin
                frame_end = 1'b1;
                fe_one = 0;
            end else begin
                frame_end = 1'b0;
            end
        end
    end

    // R5 monitor: the enable only drops after an edge that saw frame end.
    bit prev_en = 0;
    always @(negedge clk_disp) begin
        if (rst_n) begin
            if (prev_en && !disp_en) begin
                n_fall++;
                chk(frame_end, "R5 drop without frame end", {31'b0, frame_end}, 32'd1);
            end
            prev_en = disp_en;
        end
    end

    // R2 monitor: bit 0 only moves right after a busy cycle.
    bit prev_rd0 = 0;
    bit prev_busy = 0;
    always @(negedge clk_bus) begin
        if (rst_n) begin
            if (rdata[0] != prev_rd0)
                chk(prev_busy, "R2 readback moved while idle", {31'b0, prev_busy}, 32'd1);
            prev_rd0 = rdata[0];
            prev_busy = rdata[W-1];
        end
    end

    task automatic write_en(input bit v);
        @(negedge clk_bus);
        wr = 1'b1;
        wdata = v;
        @(negedge clk_bus);
        wr = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int k = 0;
        while (rdata[W-1] && k < 2000) begin
            @(negedge clk_bus);
            k++;
        end
        chk(k < 2000, tag, rdata, exp_word(rdata[0], 0));
        repeat (2) @(negedge clk_bus);
    endtask

    task automatic pulse_frame();
        fe_one = 1;
        @(negedge clk_disp);
        @(negedge clk_disp);
        #2;
    endtask

    // Watchdog
    initial begin
        #(TB * 200000.0);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        real t0;
        real dt;
        int falls0;
        bit last;
        void'($urandom(32'd7411));

        // R1 / R9: reset state
        #20;
        chk(rdata == exp_word(0, 0), "R1 word in reset", rdata, exp_word(0, 0));
        chk(disp_en == 1'b0, "R1 enable in reset", {31'b0, disp_en}, 32'd0);
        @(negedge clk_bus);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_bus);
        chk(rdata == exp_word(0, 0), "R1 R9 word after reset", rdata, exp_word(0, 0));
        chk(disp_en == 1'b0, "R1 enable after reset", {31'b0, disp_en}, 32'd0);

        // R3 / R2 / R4: enable latency and readback lag
        @(negedge clk_bus);
        t0 = $realtime + TB / 2.0;
        wr = 1'b1;
        wdata = 1'b1;
        @(negedge clk_bus);
        wr = 1'b0;
        chk(rdata == exp_word(0, 1), "R4 R2 busy after enable write", rdata, exp_word(0, 1));
        begin
            int g = 0;
            while (!disp_en && g < 400) begin
                #1;
                g++;
            end
        end
        dt = $realtime - t0;
        chk(dt > TD && dt <= 2.0 * TD + TB + 1.0, "R3 enable latency",
            $rtoi(dt), $rtoi(2.0 * TD + TB));
        chk(rdata[0] == 1'b0, "R2 readback lags enable", rdata, exp_word(0, 1));
        wait_idle("R4 busy clears after enable");
        chk(rdata == exp_word(1, 0), "R2 readback after enable", rdata, exp_word(1, 0));
        chk(disp_en == 1'b1, "R3 enable held", {31'b0, disp_en}, 32'd1);

        // R6: rewrite the settled value
        write_en(1'b1);
        chk(rdata == exp_word(1, 0), "R6 same-value write", rdata, exp_word(1, 0));
        repeat (10) @(negedge clk_bus);
        chk(rdata == exp_word(1, 0), "R6 no later change", rdata, exp_word(1, 0));

        // R8: frame end while on and requested
        pulse_frame();
        repeat (3) @(negedge clk_disp);
        chk(disp_en == 1'b1, "R8 frame end while on", {31'b0, disp_en}, 32'd1);

        // R5: disable waits for the frame end
        write_en(1'b0);
        chk(rdata == exp_word(1, 1), "R4 busy after disable write", rdata, exp_word(1, 1));
        repeat (20) @(negedge clk_disp);
        chk(disp_en == 1'b1, "R5 enable held until frame end", {31'b0, disp_en}, 32'd1);
        chk(rdata == exp_word(1, 1), "R5 busy while waiting", rdata, exp_word(1, 1));
        pulse_frame();
        chk(disp_en == 1'b0, "R5 enable drops at frame end", {31'b0, disp_en}, 32'd0);
        wait_idle("R4 busy clears after disable");
        chk(rdata == exp_word(0, 0), "R2 readback after disable", rdata, exp_word(0, 0));

        // R8: frame end while off
        pulse_frame();
        repeat (3) @(negedge clk_disp);
        chk(disp_en == 1'b0, "R8 frame end while off", {31'b0, disp_en}, 32'd0);

        // R7: reverse a pending disable
        write_en(1'b1);
        wait_idle("R4 enable again");
        falls0 = n_fall;
        write_en(1'b0);
        repeat (3) @(negedge clk_bus);
        write_en(1'b1);
        chk(rdata[W-1] == 1'b1, "R7 busy while reversed", rdata, exp_word(1, 1));
        repeat (20) @(negedge clk_disp);
        chk(disp_en == 1'b1, "R7 still on before frame end", {31'b0, disp_en}, 32'd1);
        pulse_frame();
        wait_idle("R7 settle after reversal");
        chk(rdata == exp_word(1, 0), "R7 settles on latest", rdata, exp_word(1, 0));
        chk(disp_en == 1'b1, "R7 enable on latest", {31'b0, disp_en}, 32'd1);
        chk(n_fall == falls0 + 1, "R7 pending disable completed",
            n_fall - falls0, 32'd1);

        // R7: back-to-back on/off from off with free-running frames
        fe_auto = 1;
        write_en(1'b0);
        wait_idle("R7 off before short pulse");
        write_en(1'b1);
        write_en(1'b0);
        wait_idle("R7 settle after short pulse");
        chk(rdata == exp_word(0, 0), "R7 short pulse ends off", rdata, exp_word(0, 0));
        chk(disp_en == 1'b0, "R7 short pulse enable", {31'b0, disp_en}, 32'd0);

        // Random writes against free-running frames
        last = 1'b0;
        for (int it = 0; it < 40; it++) begin
            bit v;
            v = 1'($urandom_range(0, 1));
            write_en(v);
            last = v;
            repeat ($urandom_range(0, 60)) @(negedge clk_bus);
            if ($urandom_range(0, 2) == 0 || it == 39) begin
                wait_idle("R4 random settle");
                chk(rdata == exp_word(last, 0), "R7 R9 random final word", rdata, exp_word(last, 0));
                chk(disp_en == last, "R7 random final enable", {31'b0, disp_en}, {31'b0, last});
            end
        end

        finish_run();
    end

endmodule